// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Command Engine

This block is the device-side command logic of a page-oriented serial flash with two byte buffers in SRAM. It takes SPI mode-0 frames on chip select, serial clock and serial data-in. Those three lines are synchronised to the system clock, and the data line is sampled on each rising serial clock while chip select is low. The first 32 bits of a frame form a header: an 8-bit opcode, a reserved bit, a 13-bit page number and a 10-bit byte column, all sent most significant bit first.

A program-through-buffer header turns the rest of the frame into a byte stream. Each byte goes into the selected buffer, starting at the column and wrapping around at the buffer end. When chip select rises, the engine erases the addressed page of the external array and then writes the whole buffer into it. A transfer header instead copies one array page into the selected buffer once chip select rises. Both operations run on an internal timer. During that time the engine drops its ready pin and sets its busy status bit. The array itself sits outside the block, behind a one-strobe-per-cycle page port.

Top module: `sflash_dualbuf_engine`

## Requirements
- R1: After reset, `ready` is 1, `status_busy` is 0 and `mem_en` is 0.
- R2: The header is sampled on rising `spi_sck` while `spi_cs_n` is low. Its bit order is opcode[7:0], then one reserved bit (any value, no effect), then page[12:0], then column[9:0], each field MSB first. Opcodes 0x82/0x85 mean program through buffer 0/1. Opcodes 0x53/0x55 mean transfer a page into buffer 0/1.
- R3: In a program frame, each complete 8-bit group after the header (MSB first) is stored in the chosen buffer. The first goes at the header column and each next one at the column plus one, with column 1023 followed by 0. A trailing group of fewer than 8 bits is dropped.
- R4: When chip select rises after a program frame, the engine issues one erase strobe (`mem_op`=0) for the header page. It then issues write strobes (`mem_op`=1) for columns 0 to 1023 on consecutive cycles, each carrying that buffer byte. Write strobes only ever follow the erase for the same page.
- R5: When chip select rises after a transfer frame, the engine issues read strobes (`mem_op`=2) for columns 0 to 1023 of the header page on consecutive cycles. The byte on `mem_rdata` in the cycle after each strobe is stored at that column of the chosen buffer. The header column has no effect.
- R6: `status_busy` goes high in response to the chip-select rise that launches an operation. It stays high for exactly `T_PROG` system cycles for a program and `T_XFR` cycles for a transfer. `ready` is always its inverse.
- R7: A frame with any other opcode, or one that ends before 32 header bits, changes no buffer byte and starts no operation.
- R8: While `status_busy` is high, new frames start nothing and change no buffer byte. The busy indication stays valid throughout.
- R9: `mem_en` is asserted only while `status_busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, mode 0, asynchronous |
| spi_si | input | 1 | Serial data into the device |
| ready | output | 1 | High when no operation is running |
| status_busy | output | 1 | Status bit, high while an operation is running |
| mem_en | output | 1 | Array port strobe |
| mem_op | output | 2 | Strobe kind: 0 erase page, 1 write byte, 2 read byte |
| mem_page | output | 13 | Array page of the strobe |
| mem_col | output | 10 | Byte column of a write or read strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after a read strobe |

## Verification
The hardest case to reach is a complete, valid frame that arrives while an earlier operation is still running. Such a frame must leave both buffers and the array untouched. The stimulus starts a program operation and then, inside its busy window, sends a second program frame with data to the other buffer. That buffer is later programmed into a fresh page and compared with a model that left the ignored bytes out. Buffer contents can only be seen through the array port, so every fill, wrap, dropped partial byte and transfer is checked by programming the buffer into a page and comparing all 1024 bytes.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    // Frame format is fixed by the serial protocol.
    localparam int HDR_BITS = 32;
    localparam int PAGE_W   = 13;
    localparam int COL_W    = 10;

    localparam logic [7:0] OPC_PROG_B0 = 8'h82;
    localparam logic [7:0] OPC_PROG_B1 = 8'h85;
    localparam logic [7:0] OPC_XFR_B0  = 8'h53;
    localparam logic [7:0] OPC_XFR_B1  = 8'h55;

    typedef enum logic [1:0] {
        MEM_ERASE = 2'd0,
        MEM_WRITE = 2'd1,
        MEM_READ  = 2'd2
    } mem_op_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_PROG = 2'd1,
        KIND_XFR  = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ERASE  = 2'd1,
        SQ_STREAM = 2'd2,
        SQ_DRAIN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic               bsel;
        logic [PAGE_W-1:0]  page;
        logic [COL_W-1:0]   col;
    } cmd_t;

    // Header word layout: [31:24] opcode, [23] reserved, [22:10] page, [9:0] column.
    function automatic cmd_t decode_hdr(input logic [HDR_BITS-1:0] w);
        cmd_t       c;
        logic [7:0] opc;
        opc    = w[HDR_BITS-1 -: 8];
        c.page = w[COL_W +: PAGE_W];
        c.col  = w[COL_W-1:0];
        c.bsel = (opc == OPC_PROG_B1) || (opc == OPC_XFR_B1);
        case (opc)
            OPC_PROG_B0, OPC_PROG_B1: c.kind = KIND_PROG;
            OPC_XFR_B0,  OPC_XFR_B1:  c.kind = KIND_XFR;
            default:                  c.kind = KIND_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfe_spi_rx.sv
module sfe_spi_rx #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic bit_stb,
    output logic bit_val,
    output logic frame_begin,
    output logic frame_end
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] cs_s, sck_s, si_s;
    logic         cs_q, sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_s  <= '1;
            sck_s <= '0;
            si_s  <= '0;
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_s  <= {cs_s[TOP-1:0], cs_n};
            sck_s <= {sck_s[TOP-1:0], sck};
            si_s  <= {si_s[TOP-1:0], si};
            cs_q  <= cs_s[TOP];
            sck_q <= sck_s[TOP];
        end
    end

    assign bit_stb     = ~cs_s[TOP] & sck_s[TOP] & ~sck_q;
    assign bit_val     = si_s[TOP];
    assign frame_begin = ~cs_s[TOP] & cs_q;
    assign frame_end   = cs_s[TOP] & ~cs_q;

endmodule

// File: rtl/sfe_frame.sv
module sfe_frame
    import sfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              frame_begin,
    input  logic              frame_end,
    input  logic              busy,
    output logic              launch,
    output cmd_kind_e         launch_kind,
    output logic              launch_bsel,
    output logic [PAGE_W-1:0] launch_page,
    output logic              wr_en,
    output logic [COL_W:0]    wr_addr,
    output logic [7:0]        wr_data
);
    localparam int CNT_W = $clog2(HDR_BITS + 1);

    logic [CNT_W-1:0]    hdr_cnt;
    logic [HDR_BITS-2:0] hdr_sh;
    logic [2:0]          dat_cnt;
    logic [6:0]          dat_sh;
    logic                accepted;
    logic [COL_W-1:0]    ptr;
    cmd_t                cur, nxt;

    assign nxt         = decode_hdr({hdr_sh, bit_val});
    assign launch_kind = cur.kind;
    assign launch_bsel = cur.bsel;
    assign launch_page = cur.page;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_cnt  <= '0;
            hdr_sh   <= '0;
            dat_cnt  <= '0;
            dat_sh   <= '0;
            accepted <= 1'b0;
            ptr      <= '0;
            cur      <= '0;
            launch   <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            launch <= 1'b0;
            wr_en  <= 1'b0;
            if (frame_begin) begin
                hdr_cnt  <= '0;
                dat_cnt  <= '0;
                accepted <= 1'b0;
            end else if (bit_stb) begin
                if (hdr_cnt != CNT_W'(HDR_BITS)) begin
                    hdr_sh  <= {hdr_sh[HDR_BITS-3:0], bit_val};
                    hdr_cnt <= hdr_cnt + 1'b1;
                    if (hdr_cnt == CNT_W'(HDR_BITS - 1)) begin
                        cur      <= nxt;
                        ptr      <= nxt.col;
                        accepted <= (nxt.kind != KIND_NONE) && !busy;
                    end
                end else begin
                    dat_sh  <= {dat_sh[5:0], bit_val};
                    dat_cnt <= dat_cnt + 1'b1;
                    if (dat_cnt == 3'd7 && accepted && cur.kind == KIND_PROG) begin
                        wr_en   <= 1'b1;
                        wr_addr <= {cur.bsel, ptr};
                        wr_data <= {dat_sh, bit_val};
                        ptr     <= ptr + 1'b1;
                    end
                end
            end
            if (frame_end) begin
                launch   <= accepted && !busy;
                accepted <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sfe_bufs.sv
module sfe_bufs #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [7:0]    a_data,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [7:0]    b_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) store[a_addr] <= a_data;
        if (b_we) store[b_addr] <= b_data;
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
    import sfe_pkg::*;
#(
    parameter int T_PROG = 1500,
    parameter int T_XFR  = 1200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  cmd_kind_e         launch_kind,
    input  logic              launch_bsel,
    input  logic [PAGE_W-1:0] launch_page,
    input  logic [7:0]        buf_rd_data,
    output logic [COL_W:0]    buf_rd_addr,
    input  logic [7:0]        mem_rdata,
    output logic              fill_we,
    output logic [COL_W:0]    fill_addr,
    output logic [7:0]        fill_data,
    output logic              busy,
    output logic              mem_en,
    output mem_op_e           mem_op,
    output logic [PAGE_W-1:0] mem_page,
    output logic [COL_W-1:0]  mem_col,
    output logic [7:0]        mem_wdata
);
    localparam int T_MAX = (T_PROG > T_XFR) ? T_PROG : T_XFR;
    localparam int TW    = $clog2(T_MAX + 1);

    seq_state_e        state;
    cmd_kind_e         kind;
    logic              bsel;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  idx;
    logic [TW-1:0]     tmr;
    logic              rd_pend;
    logic [COL_W-1:0]  rd_col;

    assign buf_rd_addr = {bsel, idx};
    assign fill_we     = rd_pend;
    assign fill_addr   = {bsel, rd_col};
    assign fill_data   = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            kind      <= KIND_NONE;
            bsel      <= 1'b0;
            page      <= '0;
            idx       <= '0;
            tmr       <= '0;
            busy      <= 1'b0;
            rd_pend   <= 1'b0;
            rd_col    <= '0;
            mem_en    <= 1'b0;
            mem_op    <= MEM_ERASE;
            mem_page  <= '0;
            mem_col   <= '0;
            mem_wdata <= '0;
        end else begin
            mem_en  <= 1'b0;
            rd_pend <= mem_en && (mem_op == MEM_READ);
            rd_col  <= mem_col;

            if (busy) begin
                if (tmr != '0)            tmr  <= tmr - 1'b1;
                else if (state == SQ_IDLE) busy <= 1'b0;
            end

            unique case (state)
                SQ_IDLE: if (launch && !busy) begin
                    busy  <= 1'b1;
                    tmr   <= (launch_kind == KIND_PROG) ? TW'(T_PROG - 1) : TW'(T_XFR - 1);
                    kind  <= launch_kind;
                    bsel  <= launch_bsel;
                    page  <= launch_page;
                    idx   <= '0;
                    state <= (launch_kind == KIND_PROG) ? SQ_ERASE : SQ_STREAM;
                end
                SQ_ERASE: begin
                    mem_en   <= 1'b1;
                    mem_op   <= MEM_ERASE;
                    mem_page <= page;
                    mem_col  <= '0;
                    state    <= SQ_STREAM;
                end
                SQ_STREAM: begin
                    mem_en    <= 1'b1;
                    mem_op    <= (kind == KIND_PROG) ? MEM_WRITE : MEM_READ;
                    mem_page  <= page;
                    mem_col   <= idx;
                    mem_wdata <= buf_rd_data;
                    idx       <= idx + 1'b1;
                    if (idx == '1) state <= SQ_DRAIN;
                end
                SQ_DRAIN: state <= SQ_IDLE;
                default:  state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sflash_dualbuf_engine.sv
module sflash_dualbuf_engine
    import sfe_pkg::*;
#(
    parameter int T_PROG      = 1500,
    parameter int T_XFR       = 1200,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    output logic              ready,
    output logic              status_busy,
    output logic              mem_en,
    output logic [1:0]        mem_op,
    output logic [PAGE_W-1:0] mem_page,
    output logic [COL_W-1:0]  mem_col,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int BUF_AW = COL_W + 1;

    logic              bit_stb, bit_val, frame_begin, frame_end;
    logic              launch_w, launch_bsel, busy;
    cmd_kind_e         launch_kind;
    logic [PAGE_W-1:0] launch_page;
    logic              spi_we, fill_we;
    logic [BUF_AW-1:0] spi_addr, fill_addr, rd_addr;
    logic [7:0]        spi_data, fill_data, rd_data;
    mem_op_e           op_w;

    sfe_spi_rx #(.STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .si(spi_si),
        .bit_stb(bit_stb), .bit_val(bit_val),
        .frame_begin(frame_begin), .frame_end(frame_end)
    );

    sfe_frame u_frame (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
        .frame_begin(frame_begin), .frame_end(frame_end), .busy(busy),
        .launch(launch_w), .launch_kind(launch_kind), .launch_bsel(launch_bsel),
        .launch_page(launch_page),
        .wr_en(spi_we), .wr_addr(spi_addr), .wr_data(spi_data)
    );

    sfe_bufs #(.AW(BUF_AW)) u_bufs (
        .clk(clk),
        .a_we(spi_we), .a_addr(spi_addr), .a_data(spi_data),
        .b_we(fill_we), .b_addr(fill_addr), .b_data(fill_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    sfe_seq #(.T_PROG(T_PROG), .T_XFR(T_XFR)) u_seq (
        .clk(clk), .rst(rst), .launch(launch_w), .launch_kind(launch_kind),
        .launch_bsel(launch_bsel), .launch_page(launch_page),
        .buf_rd_data(rd_data), .buf_rd_addr(rd_addr), .mem_rdata(mem_rdata),
        .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
        .busy(busy), .mem_en(mem_en), .mem_op(op_w), .mem_page(mem_page),
        .mem_col(mem_col), .mem_wdata(mem_wdata)
    );

    assign mem_op      = op_w;
    assign ready       = ~busy;
    assign status_busy = busy;

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker #(
    parameter int COLW = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            ready,
    input logic            status_busy,
    input logic            mem_en,
    input logic [1:0]      mem_op,
    input logic [COLW-1:0] mem_col,
    input logic            launch
);
    // R9: array strobes only inside the busy window
    assert_strobe_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> status_busy);

    // R4: erase strobe is followed at once by the write of column 0
    assert_erase_then_write_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_op == 2'd0) |=> (mem_en && mem_op == 2'd1 && mem_col == '0));

    // R4: writes walk the columns one per cycle
    assert_write_walk_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_op == 2'd1 && mem_col != '1) |=>
        (mem_en && mem_op == 2'd1 && mem_col == COLW'($past(mem_col) + 1'b1)));

    // R5: reads walk the columns one per cycle
    assert_read_walk_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_op == 2'd2 && mem_col != '1) |=>
        (mem_en && mem_op == 2'd2 && mem_col == COLW'($past(mem_col) + 1'b1)));

    // R6: busy only starts on a launch from the frame logic
    assert_busy_from_launch_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(status_busy) |-> $past(launch));

    // R8: no launch is produced while busy
    assert_no_launch_busy_R8: assert property (@(posedge clk) disable iff (rst)
        status_busy |-> !launch);

    // R6: pin and status bit agree
    always_comb begin
        if (!rst) assert_pin_matches_status_R6: assert (ready == !status_busy);
    end

endmodule

bind sflash_dualbuf_engine sfe_checker #(.COLW(sfe_pkg::COL_W)) u_chk (
    .clk(clk), .rst(rst), .ready(ready), .status_busy(status_busy),
    .mem_en(mem_en), .mem_op(mem_op), .mem_col(mem_col), .launch(launch_w)
);

// File: tb/sflash_dualbuf_engine_test.sv
module sflash_dualbuf_engine_test;
    localparam int TP = 1500;
    localparam int TX = 1200;
    localparam int HP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0;
    logic        ready, status_busy, mem_en;
    logic [1:0]  mem_op;
    logic [12:0] mem_page;
    logic [9:0]  mem_col;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    always #2 clk = ~clk;

    sflash_dualbuf_engine #(.T_PROG(TP), .T_XFR(TX), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_si(spi_si),
        .ready(ready), .status_busy(status_busy), .mem_en(mem_en), .mem_op(mem_op),
        .mem_page(mem_page), .mem_col(mem_col), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int n_checks = 0, n_fail = 0;
    int erase_cnt = 0, wr_cnt = 0, order_err = 0, busy_cnt = 0, pin_err = 0;
    int last_erase = -1;
    bit done = 0;
    logic [7:0] fmem [int];
    logic [7:0] bmodel [2][1024];
    logic [7:0] tx_data [64];

    // Array model behind the page port
    always @(posedge clk) begin
        if (mem_en) begin
            int k;
            k = int'(mem_page) * 1024 + int'(mem_col);
            case (mem_op)
                2'd0: begin
                    for (int c = 0; c < 1024; c++) fmem[int'(mem_page) * 1024 + c] = 8'hFF;
                    erase_cnt++;
                    last_erase = int'(mem_page);
                end
                2'd1: begin
                    fmem[k] = mem_wdata;
                    wr_cnt++;
                    if (int'(mem_page) != last_erase) order_err++;
                end
                2'd2: mem_rdata <= fmem.exists(k) ? fmem[k] : 8'hFF;
                default: order_err++;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (status_busy) busy_cnt++;
            if (ready !== !status_busy) pin_err++;
        end
    end

    function automatic logic [7:0] mem_rd(input int pg, input int c);
        int k;
        k = pg * 1024 + c;
        return fmem.exists(k) ? fmem[k] : 8'hFF;
    endfunction

    function automatic int page_diff(input int pg, input int b);
        int n;
        n = 0;
        for (int c = 0; c < 1024; c++) if (mem_rd(pg, c) !== bmodel[b][c]) n++;
        return n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b);
        spi_si = b;
        repeat (HP) @(negedge clk);
        spi_sck = 1'b1;
        repeat (HP) @(negedge clk);
        spi_sck = 1'b0;
    endtask

    // Sends a header plus data bytes, cut at total_bits when total_bits >= 0
    task automatic send_frame(input logic [7:0] opc, input logic rsv, input int pg,
                              input int col, input int nbytes, input int total_bits);
        logic [31:0] hdr;
        int          nb;
        hdr = {opc, rsv, 13'(pg), 10'(col)};
        nb  = (total_bits >= 0) ? total_bits : 32 + 8 * nbytes;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            if (i < 32) spi_bit(hdr[31 - i]);
            else        spi_bit(tx_data[(i - 32) / 8][7 - ((i - 32) % 8)]);
        end
        repeat (HP) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_idle();
        repeat (10) @(negedge clk);
        while (status_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic fill_tx(input int n);
        for (int i = 0; i < n; i++) tx_data[i] = 8'($urandom_range(0, 255));
    endtask

    task automatic model_write(input int b, input int col, input int n);
        for (int i = 0; i < n; i++) bmodel[b][(col + i) % 1024] = tx_data[i];
    endtask

    // Program: frame, wait, check busy length, strobe counts and page contents
    task automatic do_prog(input string req, input int b, input int pg, input int col,
                           input int n, input int extra_bits);
        int e0, w0;
        e0 = erase_cnt; w0 = wr_cnt; busy_cnt = 0;
        model_write(b, col, n);
        send_frame(b ? 8'h85 : 8'h82, 1'($urandom_range(0, 1)), pg, col, n + 1,
                   32 + 8 * n + extra_bits);
        wait_idle();
        chk({req, " busy length (R6)"}, busy_cnt, TP);
        chk({req, " erase count (R4)"}, erase_cnt - e0, 1);
        chk({req, " write count (R4)"}, wr_cnt - w0, 1024);
        chk({req, " page mismatches"}, page_diff(pg, b), 0);
    endtask

    task automatic do_xfr(input string req, input int b, input int pg, input int col);
        busy_cnt = 0;
        for (int c = 0; c < 1024; c++) bmodel[b][c] = mem_rd(pg, c);
        send_frame(b ? 8'h55 : 8'h53, 1'b0, pg, col, 0, -1);
        wait_idle();
        chk({req, " busy length (R6)"}, busy_cnt, TX);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (10) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready", int'(ready), 1);
        chk("R1 status_busy", int'(status_busy), 0);
        chk("R1 mem_en", int'(mem_en), 0);

        // Load both buffers from erased pages, column bits set (R5)
        do_xfr("R5 init buf0", 0, 100, 10'h3A5);
        do_xfr("R5 init buf1", 1, 101, 10'h001);

        // Wrap from column 1020 (R3, R4)
        fill_tx(8);
        do_prog("R3 wrap", 0, 5, 1020, 8, 0);

        // Trailing partial group dropped (R3)
        fill_tx(3);
        do_prog("R3 partial byte", 1, 6, 3, 2, 5);

        // Page to buffer, then program that buffer elsewhere (R5)
        do_xfr("R5 copy page 5", 1, 5, 10'h2FF);
        do_prog("R5 copy check", 1, 7, 0, 0, 0);

        // Unknown opcode with data: nothing happens (R7)
        begin
            int e0, w0;
            e0 = erase_cnt; w0 = wr_cnt; busy_cnt = 0;
            fill_tx(4);
            send_frame(8'h84, 1'b0, 8, 0, 4, -1);
            wait_idle();
            chk("R7 unknown opcode busy", busy_cnt, 0);
            chk("R7 unknown opcode strobes", (erase_cnt - e0) + (wr_cnt - w0), 0);
            fill_tx(4);
            send_frame(8'h82, 1'b0, 8, 0, 0, 20);
            wait_idle();
            chk("R7 aborted header busy", busy_cnt, 0);
            send_frame(8'h85, 1'b0, 8, 0, 0, 31);
            wait_idle();
            chk("R7 31-bit header busy", busy_cnt, 0);
            chk("R7 aborted strobes", (erase_cnt - e0) + (wr_cnt - w0), 0);
            do_prog("R7 buf0 untouched", 0, 9, 0, 0, 0);
        end

        // Frame while busy is ignored (R8)
        begin
            int e0, w0;
            e0 = erase_cnt; w0 = wr_cnt; busy_cnt = 0;
            fill_tx(3);
            model_write(0, 40, 3);
            send_frame(8'h82, 1'b0, 10, 40, 3, -1);
            chk("R8 busy after launch", int'(status_busy), 1);
            fill_tx(2);
            send_frame(8'h85, 1'b0, 11, 0, 2, -1);
            chk("R8 status readable during op", int'(status_busy), 1);
            wait_idle();
            chk("R8 single busy window", busy_cnt, TP);
            chk("R8 erase count", erase_cnt - e0, 1);
            chk("R8 write count", wr_cnt - w0, 1024);
            chk("R8 page 10 content", page_diff(10, 0), 0);
            do_prog("R8 buf1 untouched", 1, 12, 0, 0, 0);
        end

        // Random mix of commands (R2, R3, R4, R5)
        for (int it = 0; it < 14; it++) begin
            int b, pg, col, n;
            b   = $urandom_range(0, 1);
            pg  = $urandom_range(0, 8191);
            col = $urandom_range(0, 1023);
            n   = $urandom_range(0, 20);
            if ($urandom_range(0, 2) == 0) begin
                do_xfr("R2 random transfer", b, pg, col);
            end else begin
                fill_tx(n + 1);
                do_prog("R2 random program", b, pg, col, n, $urandom_range(0, 7));
            end
        end

        chk("R4 write before erase", order_err, 0);
        chk("R6 ready vs status", pin_err, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule